// File: doc/BRIEF.md
# Blank Page Classifier

This block sits beside the read data path of a flash controller and decides, page by page, whether the page just read is blank. A blank page is one that was erased and never programmed. While a page streams in, the block counts the zero bits in every accepted data beat. When the page is over, it compares that count with a programmable limit. If ECC checking is on, it also weighs the verdict that the external ECC decoder gives for the same page.

The result is a held erased flag and an error-mask signal. The status logic uses the mask to hold back the uncorrectable-error report for a blank page. A separate failure output carries only the ECC veto and is never raised by a blank verdict. Configuration (ECC on/off and the zero limit) must stay stable from the page-start marker until the verdict is out. The ECC decoder itself lies outside this block.

Top module: `blank_page_judge`

## Requirements
- R1: While reset is high and after it is released, `verdict_done`, `page_erased`, `unc_mask` and `page_fail` are all 0 until a page is judged.
- R2: The zero count for a page is the sum of the zero bits of every beat with `beat_valid` high. A beat on the cycle of the start marker is counted, and so is a beat on the cycle of the end marker. Beats with `beat_valid` low add nothing.
- R3: The zero-count condition holds only when the count is strictly less than `cfg_zero_limit`.
- R4: With `cfg_ecc_en` low, `page_erased` equals the zero-count condition, and the ECC inputs have no effect on any output.
- R5: With `cfg_ecc_en` high, `page_erased` is 1 only when the zero-count condition holds and the page ECC code is 2'b00 (clean) or 2'b01 (corrected).
- R6: With `cfg_ecc_en` high, an ECC code of 2'b10 (uncorrectable) or 2'b11 (reserved, handled as uncorrectable) forces `page_erased` to 0 and sets `page_fail` to 1.
- R7: `unc_mask` is 1 exactly when the page is judged erased. `page_fail` is never 1 while `page_erased` is 1, and it stays 0 whenever ECC is off.
- R8: With ECC off, the outputs take their verdict on the clock edge that samples `pg_end`. With ECC on, they take it on the first edge by which both `pg_end` and an ECC strobe for the page have been sampled, so `verdict_done` stays 0 while the ECC result is missing. The verdict holds until an edge that samples `pg_start`, which clears all four outputs.
- R9: The zero count saturates at 2^CNT_W-1 instead of wrapping, so an all-zero page longer than that range is never judged erased when the limit is 2^CNT_W-1.
- R10: Only the first `ecc_valid` strobe of a page is used. Later strobes in the same page, and strobes that arrive after the verdict, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ecc_en | input | 1 | ECC result gates the verdict when 1 |
| cfg_zero_limit | input | CNT_W | Zero-bit count below which a page is blank |
| pg_start | input | 1 | First cycle of a page |
| pg_end | input | 1 | Last cycle of a page |
| beat_valid | input | 1 | Data beat present |
| beat_data | input | DATA_W | Data beat |
| ecc_valid | input | 1 | ECC result strobe for the current page |
| ecc_code | input | 2 | 00 clean, 01 corrected, 10 uncorrectable, 11 reserved |
| verdict_done | output | 1 | Verdict for the current page is available |
| page_erased | output | 1 | Page judged blank |
| unc_mask | output | 1 | Suppress the uncorrectable-error report |
| page_fail | output | 1 | Uncorrectable ECC result with ECC on |

## Verification
A wrong zero count shows up in the first verdict after the bad beat. If the count is off by even one bit, `page_erased` flips in the boundary vectors, where the limit sits one above or exactly at the true count. A count that wraps instead of saturating makes the long all-zero page look blank. A stale or lost ECC capture shows as `verdict_done` rising one or more cycles early or late, or as a later strobe overriding the first. Every fault of this kind is visible within one cycle of the end marker or the ECC strobe.

// File: rtl/bpj_pkg.sv
package bpj_pkg;

  typedef enum logic [1:0] {
    ECC_CLEAN = 2'b00,
    ECC_FIXED = 2'b01,
    ECC_FATAL = 2'b10,
    ECC_RSVD  = 2'b11
  } ecc_res_e;

  // A result that is not clean or corrected vetoes the blank verdict.
  function automatic logic ecc_blocks(input logic [1:0] code);
    return (code == ECC_FATAL) || (code == ECC_RSVD);
  endfunction

endpackage

// File: rtl/bpj_zero_counter.sv
module bpj_zero_counter #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              beat_valid_i,
  input  logic [DATA_W-1:0] beat_data_i,
  output logic [CNT_W-1:0]  cnt_next_o
);

  localparam int ZW = $clog2(DATA_W + 1);
  localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

  logic [ZW-1:0]    beat_zeros;
  logic [CNT_W:0]   base;
  logic [CNT_W:0]   sum;
  logic             take;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  // Population count of the inverted beat.
  always_comb begin
    beat_zeros = '0;
    for (int i = 0; i < DATA_W; i++) begin
      beat_zeros = beat_zeros + ZW'(~beat_data_i[i]);
    end
  end

  always_comb begin
    base  = clr_i ? '0 : {1'b0, cnt_q};
    sum   = base + (CNT_W + 1)'(beat_zeros);
    take  = beat_valid_i && (clr_i || en_i);
    cnt_d = clr_i ? '0 : cnt_q;
    if (take) begin
      cnt_d = (sum > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : sum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_next_o = cnt_d;

  // R9: once saturated the count stays pinned until the next page.
  p_sat_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX[CNT_W-1:0] && !clr_i) |=> (cnt_q == CNT_MAX[CNT_W-1:0]));

  // R2: within a page the count never decreases.
  p_cnt_mono_r2: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> (cnt_q >= $past(cnt_q)));

endmodule

// File: rtl/bpj_ecc_capture.sv
module bpj_ecc_capture (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr_i,
  input  logic       armed_i,
  input  logic       ecc_valid_i,
  input  logic [1:0] ecc_code_i,
  output logic       seen_o,
  output logic [1:0] code_o
);

  logic       seen_q;
  logic [1:0] code_q;
  logic       keep;
  logic       take;

  always_comb begin
    keep   = seen_q && !clr_i;
    take   = armed_i && ecc_valid_i && !keep;
    seen_o = keep || take;
    code_o = keep ? code_q : ecc_code_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      code_q <= 2'b00;
    end else begin
      seen_q <= seen_o;
      if (take) begin
        code_q <= ecc_code_i;
      end
    end
  end

  // R10: the first captured result is never overwritten within a page.
  p_first_kept_r10: assert property (@(posedge clk) disable iff (rst)
    (seen_q && !clr_i) |=> $stable(code_q));

endmodule

// File: rtl/bpj_verdict.sv
module bpj_verdict
  import bpj_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pg_start_i,
  input  logic             pg_end_i,
  input  logic             cfg_ecc_en_i,
  input  logic [CNT_W-1:0] cfg_limit_i,
  input  logic [CNT_W-1:0] cnt_next_i,
  input  logic             ecc_seen_i,
  input  logic [1:0]       ecc_code_i,
  output logic             armed_o,
  output logic             cnt_en_o,
  output logic             done_o,
  output logic             erased_o,
  output logic             mask_o,
  output logic             fail_o
);

  logic active_q;
  logic end_seen_q;
  logic end_now;
  logic end_any;
  logic ecc_ready;
  logic decide;
  logic zero_ok;
  logic blocked;
  logic er_d;

  always_comb begin
    armed_o   = active_q || pg_start_i;
    cnt_en_o  = active_q && !end_seen_q;
    end_now   = pg_end_i && armed_o;
    end_any   = end_now || (end_seen_q && !pg_start_i);
    ecc_ready = !cfg_ecc_en_i || ecc_seen_i;
    decide    = armed_o && end_any && ecc_ready;
    zero_ok   = cnt_next_i < cfg_limit_i;
    blocked   = cfg_ecc_en_i && ecc_blocks(ecc_code_i);
    er_d      = zero_ok && !blocked;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q   <= 1'b0;
      end_seen_q <= 1'b0;
      done_o     <= 1'b0;
      erased_o   <= 1'b0;
      mask_o     <= 1'b0;
      fail_o     <= 1'b0;
    end else begin
      if (pg_start_i) begin
        active_q   <= 1'b1;
        end_seen_q <= 1'b0;
        done_o     <= 1'b0;
        erased_o   <= 1'b0;
        mask_o     <= 1'b0;
        fail_o     <= 1'b0;
      end
      if (end_now && !ecc_ready) begin
        end_seen_q <= 1'b1;
      end
      if (decide) begin
        active_q   <= 1'b0;
        end_seen_q <= 1'b0;
        done_o     <= 1'b1;
        erased_o   <= er_d;
        mask_o     <= er_d;
        fail_o     <= blocked;
      end
    end
  end

  // R7: a blank verdict and a failure never coexist.
  p_fail_excl_r7: assert property (@(posedge clk) disable iff (rst)
    erased_o |-> !fail_o);

  // R8: the verdict is held until a new page starts.
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (done_o && !pg_start_i) |=> (done_o && $stable(erased_o) && $stable(fail_o)));

  // R8: a start marker without an end marker clears the verdict.
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (pg_start_i && !pg_end_i) |=> !done_o);

  // R8: with ECC on, no verdict appears before an ECC result is known.
  p_wait_ecc_r8: assert property (@(posedge clk) disable iff (rst)
    (!done_o && cfg_ecc_en_i && !ecc_seen_i) |=> !done_o);

endmodule

// File: rtl/blank_page_judge.sv
module blank_page_judge #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_ecc_en,
  input  logic [CNT_W-1:0]  cfg_zero_limit,
  input  logic              pg_start,
  input  logic              pg_end,
  input  logic              beat_valid,
  input  logic [DATA_W-1:0] beat_data,
  input  logic              ecc_valid,
  input  logic [1:0]        ecc_code,
  output logic              verdict_done,
  output logic              page_erased,
  output logic              unc_mask,
  output logic              page_fail
);

  logic             armed;
  logic             cnt_en;
  logic [CNT_W-1:0] cnt_next;
  logic             ecc_seen;
  logic [1:0]       ecc_res;

  bpj_zero_counter #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_count (
    .clk          (clk),
    .rst          (rst),
    .clr_i        (pg_start),
    .en_i         (cnt_en),
    .beat_valid_i (beat_valid),
    .beat_data_i  (beat_data),
    .cnt_next_o   (cnt_next)
  );

  bpj_ecc_capture u_ecc (
    .clk         (clk),
    .rst         (rst),
    .clr_i       (pg_start),
    .armed_i     (armed),
    .ecc_valid_i (ecc_valid),
    .ecc_code_i  (ecc_code),
    .seen_o      (ecc_seen),
    .code_o      (ecc_res)
  );

  bpj_verdict #(
    .CNT_W (CNT_W)
  ) u_judge (
    .clk          (clk),
    .rst          (rst),
    .pg_start_i   (pg_start),
    .pg_end_i     (pg_end),
    .cfg_ecc_en_i (cfg_ecc_en),
    .cfg_limit_i  (cfg_zero_limit),
    .cnt_next_i   (cnt_next),
    .ecc_seen_i   (ecc_seen),
    .ecc_code_i   (ecc_res),
    .armed_o      (armed),
    .cnt_en_o     (cnt_en),
    .done_o       (verdict_done),
    .erased_o     (page_erased),
    .mask_o       (unc_mask),
    .fail_o       (page_fail)
  );

endmodule

// File: tb/test_blank_page_judge.sv
module test_blank_page_judge;

  localparam int DATA_W = 16;
  localparam int CNT_W  = 16;

  logic              clk = 1'b0;
  logic              rst;
  logic              cfg_ecc_en;
  logic [CNT_W-1:0]  cfg_zero_limit;
  logic              pg_start;
  logic              pg_end;
  logic              beat_valid;
  logic [DATA_W-1:0] beat_data;
  logic              ecc_valid;
  logic [1:0]        ecc_code;
  logic              verdict_done;
  logic              page_erased;
  logic              unc_mask;
  logic              page_fail;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  blank_page_judge #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_blank_page_judge (
    .clk(clk), .rst(rst), .cfg_ecc_en(cfg_ecc_en), .cfg_zero_limit(cfg_zero_limit),
    .pg_start(pg_start), .pg_end(pg_end), .beat_valid(beat_valid), .beat_data(beat_data),
    .ecc_valid(ecc_valid), .ecc_code(ecc_code), .verdict_done(verdict_done),
    .page_erased(page_erased), .unc_mask(unc_mask), .page_fail(page_fail)
  );

  typedef struct packed {
    logic        ecc_on;
    logic [1:0]  code;
    logic [1:0]  lag;
    logic [3:0]  nbeats;
    logic [15:0] word;
    logic [15:0] limit;
    logic        exp_er;
    logic        exp_fail;
  } vec_t;

  // Each beat is followed by an idle cycle carrying all-zero data (R2).
  localparam vec_t VECS [10] = '{
    '{1'b0, 2'b00, 2'd0, 4'd4, 16'hFFFE, 16'd5,  1'b1, 1'b0},
    '{1'b0, 2'b10, 2'd0, 4'd4, 16'hFFFE, 16'd4,  1'b0, 1'b0},
    '{1'b0, 2'b10, 2'd0, 4'd4, 16'hFFFE, 16'd5,  1'b1, 1'b0},
    '{1'b1, 2'b00, 2'd0, 4'd3, 16'hFF00, 16'd25, 1'b1, 1'b0},
    '{1'b1, 2'b01, 2'd1, 4'd3, 16'hFF00, 16'd25, 1'b1, 1'b0},
    '{1'b1, 2'b10, 2'd2, 4'd3, 16'hFF00, 16'd25, 1'b0, 1'b1},
    '{1'b1, 2'b00, 2'd0, 4'd3, 16'hFF00, 16'd24, 1'b0, 1'b0},
    '{1'b1, 2'b11, 2'd1, 4'd2, 16'hFFFF, 16'd1,  1'b0, 1'b1},
    '{1'b1, 2'b01, 2'd0, 4'd2, 16'h0000, 16'd40, 1'b1, 1'b0},
    '{1'b0, 2'b00, 2'd0, 4'd2, 16'h0000, 16'd32, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    pg_start   = 1'b0;
    pg_end     = 1'b0;
    beat_valid = 1'b0;
    beat_data  = '0;
    ecc_valid  = 1'b0;
    ecc_code   = 2'b00;
  endtask

  task automatic run_vec(input vec_t v);
    @(negedge clk);
    cfg_ecc_en     = v.ecc_on;
    cfg_zero_limit = v.limit;
    pg_start       = 1'b1;
    for (int i = 0; i < int'(v.nbeats); i++) begin
      @(negedge clk);
      if (i == 0) chk("R8 start clears verdict_done", 16'(verdict_done), 16'd0);
      pg_start   = 1'b0;
      beat_valid = 1'b1;
      beat_data  = v.word;
      if (i == int'(v.nbeats) - 1) begin
        pg_end = 1'b1;
        if (!v.ecc_on || v.lag == 2'd0) begin
          ecc_valid = 1'b1;
          ecc_code  = v.code;
        end
      end else begin
        @(negedge clk);
        beat_valid = 1'b0;
        beat_data  = 16'h0000;
      end
    end
    @(negedge clk);
    idle_inputs();
    if (v.ecc_on && v.lag != 2'd0) begin
      chk("R8 waits for ECC", 16'(verdict_done), 16'd0);
      repeat (int'(v.lag) - 1) @(negedge clk);
      ecc_valid = 1'b1;
      ecc_code  = v.code;
      @(negedge clk);
      ecc_valid = 1'b0;
    end
    chk("R8 verdict_done", 16'(verdict_done), 16'd1);
    if (v.ecc_on) chk("R2 R3 R5 R6 page_erased", 16'(page_erased), 16'(v.exp_er));
    else          chk("R2 R3 R4 page_erased", 16'(page_erased), 16'(v.exp_er));
    chk("R7 unc_mask", 16'(unc_mask), 16'(v.exp_er));
    chk("R6 R7 page_fail", 16'(page_fail), 16'(v.exp_fail));
    repeat (3) @(negedge clk);
    chk("R8 held page_erased", 16'(page_erased), 16'(v.exp_er));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst            = 1'b1;
    cfg_ecc_en     = 1'b0;
    cfg_zero_limit = '0;
    idle_inputs();
    repeat (3) @(negedge clk);
    chk("R1 verdict_done in reset", 16'(verdict_done), 16'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 verdict_done", 16'(verdict_done), 16'd0);
    chk("R1 page_erased", 16'(page_erased), 16'd0);
    chk("R1 unc_mask", 16'(unc_mask), 16'd0);
    chk("R1 page_fail", 16'(page_fail), 16'd0);

    foreach (VECS[k]) run_vec(VECS[k]);

    // R2: single-cycle page, start and end on the same counted beat (4 zeros).
    @(negedge clk);
    cfg_ecc_en = 1'b0; cfg_zero_limit = 16'd5;
    pg_start = 1'b1; pg_end = 1'b1; beat_valid = 1'b1; beat_data = 16'hFFF0;
    @(negedge clk);
    idle_inputs();
    chk("R2 single-beat verdict_done", 16'(verdict_done), 16'd1);
    chk("R2 single-beat page_erased", 16'(page_erased), 16'd1);

    // R10: first ECC strobe (corrected) wins over a later uncorrectable one.
    @(negedge clk);
    cfg_ecc_en = 1'b1; cfg_zero_limit = 16'd3;
    pg_start = 1'b1;
    @(negedge clk);
    pg_start = 1'b0; beat_valid = 1'b1; beat_data = 16'hFFFE;
    ecc_valid = 1'b1; ecc_code = 2'b01;
    @(negedge clk);
    pg_end = 1'b1; ecc_code = 2'b10;
    @(negedge clk);
    idle_inputs();
    chk("R10 verdict_done", 16'(verdict_done), 16'd1);
    chk("R10 page_erased", 16'(page_erased), 16'd1);
    chk("R10 page_fail", 16'(page_fail), 16'd0);
    ecc_valid = 1'b1; ecc_code = 2'b11;
    @(negedge clk);
    ecc_valid = 1'b0;
    @(negedge clk);
    chk("R10 late strobe page_erased", 16'(page_erased), 16'd1);
    chk("R10 late strobe page_fail", 16'(page_fail), 16'd0);

    // R8: a start marker alone clears the held verdict.
    pg_start = 1'b1;
    @(negedge clk);
    pg_start = 1'b0;
    chk("R8 cleared verdict_done", 16'(verdict_done), 16'd0);
    chk("R8 cleared page_erased", 16'(page_erased), 16'd0);
    pg_end = 1'b1; ecc_valid = 1'b1; ecc_code = 2'b00;
    @(negedge clk);
    idle_inputs();

    // R9: 4100 all-zero beats = 65600 zeros; saturated count is not below 0xFFFF.
    @(negedge clk);
    cfg_ecc_en = 1'b0; cfg_zero_limit = 16'hFFFF;
    pg_start = 1'b1; beat_valid = 1'b1; beat_data = 16'h0000;
    for (int n = 1; n < 4100; n++) begin
      @(negedge clk);
      pg_start = 1'b0;
      if (n == 4099) pg_end = 1'b1;
    end
    @(negedge clk);
    idle_inputs();
    chk("R9 saturated verdict_done", 16'(verdict_done), 16'd1);
    chk("R9 saturated page_erased", 16'(page_erased), 16'd0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule